// File: doc/BRIEF.md
# Level Interrupt Gateway Array with Claim Tracking

This block sits in front of an interrupt controller's arbiter and turns level-sensitive source lines into pending bits. Each source has its own small gateway. While software has not taken the source, a high level raises its pending bit, and that bit stays up until a claim removes it.

Once software claims a source, the gateway blocks the line from raising the pending bit again. Instead, a hidden latch records whether the line is still asserted. When software completes the source, the gateway re-arms it. If the latch is set at that moment, the pending bit comes straight back. A line that dropped low in the meantime cleared the latch, so it does not re-pend.

Source number 0 is reserved. Claims for source 0, or for a number at or beyond the source count, are ignored.

Top module: `lgw_gateway`

## Requirements
- R1: With a source unclaimed, a high level on its line sets its pending bit on the next clock edge.
- R2: While a source is claimed, a high level does not set its pending bit. The level is recorded in that source's hidden latch.
- R3: A low level clears the source's hidden latch. A source whose line went low before completion is not pending after the completion.
- R4: A claim strobe with a valid ID n clears pending bit n and sets claimed bit n on the next clock edge.
- R5: A completion with ID n, while n is claimed, clears claimed bit n. If n's hidden latch is set in that cycle, pending bit n is set on the same edge.
- R6: A completion for an ID that is not claimed changes no pending or claimed bit.
- R7: Source 0 never becomes pending or claimed. Claims and completions with ID 0, or with an ID of NumSrc or more, are ignored.
- R8: Pending bits are sticky: a low level alone never clears one. Only a claim or a reset does.
- R9: When a claim of n and a high level on n fall in the same cycle, the claim wins. Pending n ends low, claimed n ends high, and the level goes to the hidden latch.
- R10: When a claim and a completion name the same ID in one cycle, the claim wins and the completion is dropped. Claimed n ends high and pending n ends low.
- R11: A synchronous active-high reset clears all pending bits, claimed bits and hidden latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srcLevel | input | NumSrc | Raw level of each source line; bit 0 is unused |
| claimValid | input | 1 | Claim strobe |
| claimId | input | IdW | Source number being claimed |
| completeValid | input | 1 | Completion strobe |
| completeId | input | IdW | Source number being completed |
| pending | output | NumSrc | Pending bit of each source |
| claimed | output | NumSrc | Claimed bit of each source |

## Verification
Several pairs of events can land on the same source in a single cycle:
- a claim and a rising level;
- a claim and a completion of the same ID;
- a completion and a level that is still high.

Directed cases line up each pair on one edge. Each outcome is judged from the pending and claimed vectors one cycle later, and the hidden latch is judged by whether a later completion re-pends the source. A long pseudo-random run then mixes claims, completions and level changes on all sources, including IDs outside the valid range. The bench compares both vectors every cycle against a bench model written from the requirements.

// File: rtl/lgw_pkg.sv
package lgw_pkg;
  typedef struct packed {
    logic claimGo;
    logic doneGo;
  } lgwStrobes_t;
endpackage

// File: rtl/lgw_ctrl.sv
module lgw_ctrl
  import lgw_pkg::*;
#(
  parameter int NumSrc = 24,
  parameter int IdW = (NumSrc > 1) ? $clog2(NumSrc) : 1
) (
  input  logic           claimValid,
  input  logic [IdW-1:0] claimId,
  input  logic           completeValid,
  input  logic [IdW-1:0] completeId,
  output lgwStrobes_t    strobes
);
  localparam int unsigned LastId = NumSrc - 1;

  logic claimIdOk;
  logic doneIdOk;
  logic sameId;

  // An ID is usable only if it is nonzero and names an existing source.
  assign claimIdOk = (claimId != '0) && (32'(claimId) <= LastId);
  assign doneIdOk  = (completeId != '0) && (32'(completeId) <= LastId);
  assign sameId    = (claimId == completeId);

  always_comb begin
    strobes = '0;
    strobes.claimGo = claimValid && claimIdOk;
    // A claim of the same ID in the same cycle takes precedence.
    strobes.doneGo = completeValid && doneIdOk && !(strobes.claimGo && sameId);
  end

  always_comb begin
    if (strobes.claimGo && strobes.doneGo) begin
      AST_CONFLICT_DROPPED: assert (claimId != completeId); // R10
    end
  end
endmodule

// File: rtl/lgw_cell.sv
module lgw_cell (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic claimHit,
  input  logic doneReq,
  output logic pendingQ,
  output logic claimedQ
);
  logic hiddenQ;
  logic doneHit;
  logic busyNext;
  logic pendingNext;

  // A completion only counts against a source that is claimed.
  assign doneHit  = doneReq && claimedQ;
  assign busyNext = claimHit || (claimedQ && !doneHit);

  always_comb begin
    if (claimHit) begin
      pendingNext = 1'b0;
    end else begin
      pendingNext = pendingQ || (doneHit && hiddenQ) || (level && !claimedQ);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendingQ <= 1'b0;
      claimedQ <= 1'b0;
      hiddenQ  <= 1'b0;
    end else begin
      pendingQ <= pendingNext;
      claimedQ <= busyNext;
      hiddenQ  <= level && busyNext;
    end
  end

  AST_REPEND: assert property (@(posedge clk) disable iff (rst)
    (doneHit && hiddenQ && !claimHit) |=> pendingQ); // R5
  AST_HIDDEN_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (rst)
    hiddenQ |-> claimedQ); // R2
endmodule

// File: rtl/lgw_datapath.sv
module lgw_datapath
  import lgw_pkg::*;
#(
  parameter int NumSrc = 24,
  parameter int IdW = (NumSrc > 1) ? $clog2(NumSrc) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NumSrc-1:0] srcLevel,
  input  lgwStrobes_t       strobes,
  input  logic [IdW-1:0]    claimId,
  input  logic [IdW-1:0]    completeId,
  output logic [NumSrc-1:0] pendingVec,
  output logic [NumSrc-1:0] claimedVec
);
  logic [NumSrc-1:0] claimHitVec;
  logic [NumSrc-1:0] doneReqVec;

  for (genvar g = 0; g < NumSrc; g++) begin : gSrc
    localparam logic [IdW-1:0] MyId = IdW'(g);

    assign claimHitVec[g] = strobes.claimGo && (claimId == MyId);
    assign doneReqVec[g]  = strobes.doneGo && (completeId == MyId);

    if (g == 0) begin : gReserved
      assign pendingVec[g] = 1'b0;
      assign claimedVec[g] = 1'b0;
    end else begin : gLive
      lgw_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .level    (srcLevel[g]),
        .claimHit (claimHitVec[g]),
        .doneReq  (doneReqVec[g]),
        .pendingQ (pendingVec[g]),
        .claimedQ (claimedVec[g])
      );
    end

    AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (rst)
      (claimHitVec[g] && g != 0) |=> (!pendingVec[g] && claimedVec[g])); // R4
    AST_BLOCKED_WHILE_CLAIMED: assert property (@(posedge clk) disable iff (rst)
      (claimedVec[g] && !pendingVec[g] && !doneReqVec[g]) |=> !pendingVec[g]); // R2
    AST_STICKY_PENDING: assert property (@(posedge clk) disable iff (rst)
      (pendingVec[g] && !claimHitVec[g]) |=> pendingVec[g]); // R8
    AST_STRAY_COMPLETE: assert property (@(posedge clk) disable iff (rst)
      (!claimedVec[g] && !claimHitVec[g]) |=> !claimedVec[g]); // R6
    AST_UNCLAIMED_RISE: assert property (@(posedge clk) disable iff (rst)
      (srcLevel[g] && !claimedVec[g] && !claimHitVec[g] && g != 0) |=> pendingVec[g]); // R1
  end

  AST_SRC0_QUIET: assert property (@(posedge clk) disable iff (rst)
    !strobes.claimGo || claimId != '0); // R7
endmodule

// File: rtl/lgw_gateway.sv
module lgw_gateway
  import lgw_pkg::*;
#(
  parameter int NumSrc = 24,
  parameter int IdW = (NumSrc > 1) ? $clog2(NumSrc) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NumSrc-1:0] srcLevel,
  input  logic              claimValid,
  input  logic [IdW-1:0]    claimId,
  input  logic              completeValid,
  input  logic [IdW-1:0]    completeId,
  output logic [NumSrc-1:0] pending,
  output logic [NumSrc-1:0] claimed
);
  lgwStrobes_t strobes;

  lgw_ctrl #(.NumSrc(NumSrc), .IdW(IdW)) u_ctrl (
    .claimValid    (claimValid),
    .claimId       (claimId),
    .completeValid (completeValid),
    .completeId    (completeId),
    .strobes       (strobes)
  );

  lgw_datapath #(.NumSrc(NumSrc), .IdW(IdW)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .srcLevel   (srcLevel),
    .strobes    (strobes),
    .claimId    (claimId),
    .completeId (completeId),
    .pendingVec (pending),
    .claimedVec (claimed)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (pending == '0 && claimed == '0)); // R11
endmodule

// File: tb/lgw_gateway_bench.sv
module lgw_gateway_bench;
  localparam int NumSrc = 24;
  localparam int IdW = 5;

  logic clk = 1'b0;
  logic rst;
  logic [NumSrc-1:0] srcLevel;
  logic claimValid, completeValid;
  logic [IdW-1:0] claimId, completeId;
  logic [NumSrc-1:0] pending, claimed;

  logic [NumSrc-1:0] mPend, mClm, mHid;
  int checks = 0;
  int fails = 0;
  logic [31:0] lfsr = 32'h1ace_b00c;

  always #5 clk = ~clk;

  lgw_gateway #(.NumSrc(NumSrc), .IdW(IdW)) u_lgw_gateway (
    .clk(clk), .rst(rst), .srcLevel(srcLevel),
    .claimValid(claimValid), .claimId(claimId),
    .completeValid(completeValid), .completeId(completeId),
    .pending(pending), .claimed(claimed)
  );

  task automatic check(string tag, logic [NumSrc-1:0] act, logic [NumSrc-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bench model of one clock edge, written from the requirements.
  task automatic modelEdge();
    logic [NumSrc-1:0] nP, nC, nH;
    for (int i = 0; i < NumSrc; i++) begin
      bit cH, dH, busy;
      cH = claimValid && int'(claimId) == i && i != 0;
      dH = completeValid && int'(completeId) == i && i != 0 && mClm[i] && !cH;
      busy = cH || (mClm[i] && !dH);
      nC[i] = busy;
      nH[i] = srcLevel[i] && busy;
      nP[i] = cH ? 1'b0 : (mPend[i] || (dH && mHid[i]) || (srcLevel[i] && !mClm[i]));
      if (i == 0) begin
        nP[i] = 1'b0; nC[i] = 1'b0; nH[i] = 1'b0;
      end
    end
    if (rst) begin
      nP = '0; nC = '0; nH = '0;
    end
    mPend = nP; mClm = nC; mHid = nH;
  endtask

  task automatic step(string tag);
    modelEdge();
    @(posedge clk);
    #1;
    check({tag, " pending"}, pending, mPend);
    check({tag, " claimed"}, claimed, mClm);
    @(negedge clk);
    claimValid = 1'b0;
    completeValid = 1'b0;
  endtask

  task automatic doClaim(int id, string tag);
    claimValid = 1'b1; claimId = IdW'(id); step(tag);
  endtask

  task automatic doDone(int id, string tag);
    completeValid = 1'b1; completeId = IdW'(id); step(tag);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    mPend = 'x; mClm = 'x; mHid = 'x;
    rst = 1'b1; srcLevel = '1;
    claimValid = 1'b0; completeValid = 1'b0; claimId = '0; completeId = '0;
    @(negedge clk);
    step("R11 reset");
    step("R11 reset hold");
    rst = 1'b0; srcLevel = '0;
    step("R11 idle");

    // R1 and R8
    srcLevel[3] = 1'b1; step("R1 rise");
    srcLevel[3] = 1'b0; step("R8 sticky");
    step("R8 sticky hold");

    // R4, R2, R5 with the line still high
    srcLevel[3] = 1'b1;
    doClaim(3, "R4 claim");
    step("R2 blocked");
    doDone(3, "R5 repend");

    // R3: the line drops while claimed, then completion does not re-pend
    doClaim(3, "R4 claim again");
    srcLevel[3] = 1'b0; step("R3 drop");
    doDone(3, "R3 no repend");

    // R6: stray completions
    srcLevel[5] = 1'b1; step("R6 setup");
    doDone(5, "R6 stray pending src");
    doDone(7, "R6 stray idle src");

    // R7: reserved and out-of-range IDs
    srcLevel[0] = 1'b1; step("R7 src0 level");
    doClaim(0, "R7 claim id0");
    doClaim(27, "R7 claim out of range");
    doDone(0, "R7 done id0");

    // R9: claim and a rising level on the same edge
    doClaim(5, "R9 prep");
    doDone(5, "R9 prep done");
    srcLevel[9] = 1'b1; doClaim(9, "R9 claim wins");
    doDone(9, "R9 latch repends");

    // R10: claim and completion of the same ID together
    doClaim(9, "R10 prep");
    claimValid = 1'b1; claimId = 5'd9;
    completeValid = 1'b1; completeId = 5'd9;
    step("R10 claim wins");
    doDone(9, "R10 later done");

    // Sweep: each live source through claim, blocked, complete
    srcLevel = '0;
    for (int s = 1; s < NumSrc; s++) begin
      doClaim(s, "R4 sweep clear");
      srcLevel[s] = 1'b1; step("R1 sweep");
      doClaim(s, "R4 sweep claim");
      step("R2 sweep");
      doDone(s, "R5 sweep");
      srcLevel[s] = 1'b0;
      doClaim(s, "R4 sweep reclaim");
      doDone(s, "R3 sweep done low");
    end

    // Pseudo-random mix on all sources and IDs
    for (int n = 0; n < 6000; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:1] == 3'd0) srcLevel[lfsr[12:8] % NumSrc] = ~srcLevel[lfsr[12:8] % NumSrc];
      claimValid = lfsr[4] & lfsr[5];
      claimId = lfsr[17:13];
      completeValid = lfsr[6];
      completeId = lfsr[7] ? claimId : lfsr[26:22];
      step("R1/R2/R4/R5/R6/R8/R10 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule